// File: doc/BRIEF.md
# Threshold Fault Interrupt Controller

This block gathers a set of event sources and reduces them to one registered interrupt line. There are six event sources: a clock error, a PLL lock indication, upper and lower threshold faults on a monitored analog channel, and activity-detect power-up and power-down events. There is also a small group of per-channel overload faults. Every source has three bits: a live bit that shows the present condition, a sticky latched bit, and a mask bit.

The two threshold faults come from inside the block. Each 12-bit monitor sample that arrives with a valid strobe is compared against two programmable 8-bit limits, and each limit is scaled by 16 before the compare. Software reaches the masks, the limits and the status bits through a simple register port. Read data is combinational from the address. A read strobe on a latched-status address clears that register at the clock edge.

Source bit order, used in the event mask, event latched and event live registers: bit 0 clock error, bit 1 PLL lock, bit 2 upper threshold fault, bit 3 lower threshold fault, bit 4 activity power-up, bit 5 activity power-down. The external event input carries clock error on bit 0, PLL lock on bit 1, activity power-up on bit 2 and activity power-down on bit 3. Register addresses: 0 event mask (RW), 1 event latched (RO, clear on read), 2 event live (RO), 3 upper limit (RW), 4 lower limit (RW), 5 channel mask (RW), 6 channel latched (RO, clear on read), 7 channel live (RO). Unused read bits return 0.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset the event mask reads 0x33, the channel mask reads 0, the upper limit reads 0xBA, the lower limit reads 0x4B, both latched registers and both live registers read 0, and irq_o is 0.
- R2: The live bits for the external events and the channel overloads follow their inputs in the same cycle. The two threshold live bits hold the result of the most recent valid sample.
- R3: A valid sample sets the upper threshold live bit, at the next clock edge, only when the sample is strictly greater than the upper limit times 16. A sample equal to that value clears the bit.
- R4: A valid sample sets the lower threshold live bit, at the next clock edge, only when the sample is strictly less than the lower limit times 16. A sample equal to that value clears the bit.
- R5: A latched bit becomes 1 at the clock edge after its live bit is 1. It stays 1 after the live bit falls, until it is cleared by a read.
- R6: A read strobe on a latched-status address clears that register at the clock edge. A bit whose live condition is present in the read cycle stays set, so no event is lost.
- R7: irq_o is registered. It equals the OR, over both banks, of the latched bits whose mask bit is 0, taken one clock edge earlier. A mask bit of 1 blocks its source.
- R8: Writes to the RW registers read back at once after the write edge. Writes to read-only addresses change nothing.
- R9: Channel overload faults have their own live, latched and mask bits, reset to 0, and they follow the same latching, clearing and masking rules.
- R10: A sample presented without the valid strobe leaves both threshold live bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_evt_i | input | 4 | External event levels (clock error, PLL lock, activity up, activity down) |
| smp_valid_i | input | 1 | Monitor sample valid strobe |
| smp_data_i | input | SMP_W (12) | Monitor sample |
| ovl_i | input | NUM_CH (2) | Per-channel overload fault levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears latched registers) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W (8) | Register write data |
| reg_rdata_o | output | DATA_W (8) | Register read data, combinational |
| irq_o | output | 1 | Registered interrupt output |

## Verification
On every cycle the assertions check four things. A live bit always sets its latched bit. A latched bit holds until it is read. A read clears only the bits whose condition is absent. irq_o tracks the unmasked latched bits one edge later. Also checked each cycle: the threshold flags never move without a valid strobe, and an upper flag is never raised for a sample at or below the scaled limit. The bench scenarios are needed to show the rest: the reset values of the registers, the exact comparison boundaries for several pairs of limits, an event that lands in the same cycle as a read, and writes to read-only addresses that change nothing.

// File: rtl/fic_pkg.sv
package fic_pkg;
   localparam int EVT_N  = 6;
   localparam int EXT_N  = 4;
   localparam int REG_AW = 3;

   localparam int SRC_CLKERR = 0;
   localparam int SRC_PLL    = 1;
   localparam int SRC_UPPER  = 2;
   localparam int SRC_LOWER  = 3;
   localparam int SRC_ACTUP  = 4;
   localparam int SRC_ACTDN  = 5;

   localparam logic [EVT_N-1:0] EVT_MASK_RST = 6'b110011;

   typedef enum logic [REG_AW-1:0] {
      A_EVT_MASK = 3'd0,
      A_EVT_LAT  = 3'd1,
      A_EVT_LIVE = 3'd2,
      A_THR_UP   = 3'd3,
      A_THR_LO   = 3'd4,
      A_CH_MASK  = 3'd5,
      A_CH_LAT   = 3'd6,
      A_CH_LIVE  = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/fic_thresh_cmp.sv
module fic_thresh_cmp #(
   parameter int SMP_W = 12,
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [SMP_W-1:0] sample_i,
   input  logic [THR_W-1:0] thr_up_i,
   input  logic [THR_W-1:0] thr_lo_i,
   output logic             up_flag_o,
   output logic             lo_flag_o
);
   localparam int SHIFT = SMP_W - THR_W;

   logic [SMP_W-1:0] up_scaled, lo_scaled;

   generate
      if (SHIFT < 0) begin : g_bad
         $error("fic_thresh_cmp: SMP_W must be at least THR_W");
      end else if (SHIFT == 0) begin : g_direct
         assign up_scaled = thr_up_i;
         assign lo_scaled = thr_lo_i;
      end else begin : g_scaled
         assign up_scaled = {thr_up_i, {SHIFT{1'b0}}};
         assign lo_scaled = {thr_lo_i, {SHIFT{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_flag_o <= 1'b0;
         lo_flag_o <= 1'b0;
      end else if (valid_i) begin
         up_flag_o <= sample_i > up_scaled;
         lo_flag_o <= sample_i < lo_scaled;
      end
   end

   // R10: no valid strobe, no flag movement
   a_r10_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(up_flag_o) && $stable(lo_flag_o)));
   // R3: equal or lower sample never raises the upper flag
   a_r3_no_false_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (sample_i <= up_scaled)) |=> !up_flag_o);
   // R4: equal or higher sample never raises the lower flag
   a_r4_no_false_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (sample_i >= lo_scaled)) |=> !lo_flag_o);
endmodule

// File: rtl/fic_stat_bank.sv
module fic_stat_bank #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] live_i,
   input  logic         clr_i,
   output logic [W-1:0] lat_o
);
   generate
      if (W < 1) begin : g_bad
         $error("fic_stat_bank: W must be positive");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lat_o[i] <= 1'b0;
            else        lat_o[i] <= (lat_o[i] & ~clr_i) | live_i[i];
         end

         // R5: live condition is captured at the next edge
         a_r5_live_sets: assert property (@(posedge clk) disable iff (!rst_n)
            live_i[i] |=> lat_o[i]);
         // R5: sticky until a read
         a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_o[i] && !clr_i) |=> lat_o[i]);
         // R6: a read clears bits whose condition is gone
         a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !live_i[i]) |=> !lat_o[i]);
      end
   endgenerate
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
   import fic_pkg::*;
#(
   parameter int              SMP_W  = 12,
   parameter int              THR_W  = 8,
   parameter int              NUM_CH = 2,
   parameter int              DATA_W = 8,
   parameter logic [THR_W-1:0] UP_RST = 8'hBA,
   parameter logic [THR_W-1:0] LO_RST = 8'h4B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EXT_N-1:0]  ext_evt_i,
   input  logic              smp_valid_i,
   input  logic [SMP_W-1:0]  smp_data_i,
   input  logic [NUM_CH-1:0] ovl_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);
   generate
      if (THR_W > DATA_W || NUM_CH > DATA_W || EVT_N > DATA_W) begin : g_bad_w
         $error("fault_irq_ctrl: register fields exceed DATA_W");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("fault_irq_ctrl: NUM_CH must be positive");
      end
   endgenerate

   logic [EVT_N-1:0]  evt_mask, evt_live, evt_lat;
   logic [NUM_CH-1:0] ch_mask, ch_lat;
   logic [THR_W-1:0]  thr_up, thr_lo;
   logic              up_flag, lo_flag;
   logic              evt_clr, ch_clr, irq_next;

   fic_thresh_cmp #(.SMP_W(SMP_W), .THR_W(THR_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .valid_i(smp_valid_i), .sample_i(smp_data_i),
      .thr_up_i(thr_up), .thr_lo_i(thr_lo), .up_flag_o(up_flag), .lo_flag_o(lo_flag));

   always_comb begin
      evt_live             = '0;
      evt_live[SRC_CLKERR] = ext_evt_i[0];
      evt_live[SRC_PLL]    = ext_evt_i[1];
      evt_live[SRC_UPPER]  = up_flag;
      evt_live[SRC_LOWER]  = lo_flag;
      evt_live[SRC_ACTUP]  = ext_evt_i[2];
      evt_live[SRC_ACTDN]  = ext_evt_i[3];
   end

   assign evt_clr = reg_rd_i && (reg_addr_i == A_EVT_LAT);
   assign ch_clr  = reg_rd_i && (reg_addr_i == A_CH_LAT);

   fic_stat_bank #(.W(EVT_N)) u_evt_bank (
      .clk(clk), .rst_n(rst_n), .live_i(evt_live), .clr_i(evt_clr), .lat_o(evt_lat));

   fic_stat_bank #(.W(NUM_CH)) u_ch_bank (
      .clk(clk), .rst_n(rst_n), .live_i(ovl_i), .clr_i(ch_clr), .lat_o(ch_lat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_mask <= EVT_MASK_RST;
         ch_mask  <= '0;
         thr_up   <= UP_RST;
         thr_lo   <= LO_RST;
      end else if (reg_wr_i) begin
         case (reg_addr_i)
            A_EVT_MASK: evt_mask <= reg_wdata_i[EVT_N-1:0];
            A_THR_UP:   thr_up   <= reg_wdata_i[THR_W-1:0];
            A_THR_LO:   thr_lo   <= reg_wdata_i[THR_W-1:0];
            A_CH_MASK:  ch_mask  <= reg_wdata_i[NUM_CH-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_EVT_MASK: reg_rdata_o[EVT_N-1:0]  = evt_mask;
         A_EVT_LAT:  reg_rdata_o[EVT_N-1:0]  = evt_lat;
         A_EVT_LIVE: reg_rdata_o[EVT_N-1:0]  = evt_live;
         A_THR_UP:   reg_rdata_o[THR_W-1:0]  = thr_up;
         A_THR_LO:   reg_rdata_o[THR_W-1:0]  = thr_lo;
         A_CH_MASK:  reg_rdata_o[NUM_CH-1:0] = ch_mask;
         A_CH_LAT:   reg_rdata_o[NUM_CH-1:0] = ch_lat;
         A_CH_LIVE:  reg_rdata_o[NUM_CH-1:0] = ovl_i;
         default: ;
      endcase
   end

   assign irq_next = (|(evt_lat & ~evt_mask)) | (|(ch_lat & ~ch_mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= irq_next;
   end

   // R7: an unmasked latched source raises the line one edge later
   a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(evt_lat & ~evt_mask)) || (|(ch_lat & ~ch_mask))) |=> irq_o);
   // R7: with every latched source masked or clear, the line drops
   a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|(evt_lat & ~evt_mask)) && !(|(ch_lat & ~ch_mask))) |=> !irq_o);
endmodule

// File: tb/fault_irq_ctrl_bench.sv
module fault_irq_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ext_evt = '0;
   logic       smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic [1:0] ovl = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   fault_irq_ctrl u_fault_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_evt_i(ext_evt), .smp_valid_i(smp_valid),
      .smp_data_i(smp_data), .ovl_i(ovl), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
      .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .irq_o(irq));

   // {upper limit, lower limit, sample, expect upper flag, expect lower flag}
   localparam logic [29:0] VEC [0:7] = '{
      {8'hBA, 8'h4B, 12'hBA0, 1'b0, 1'b0},
      {8'hBA, 8'h4B, 12'hBA1, 1'b1, 1'b0},
      {8'hBA, 8'h4B, 12'h4B0, 1'b0, 1'b0},
      {8'hBA, 8'h4B, 12'h4AF, 1'b0, 1'b1},
      {8'hFF, 8'h00, 12'hFFF, 1'b1, 1'b0},
      {8'hFF, 8'h00, 12'h000, 1'b0, 1'b0},
      {8'h10, 8'h20, 12'h150, 1'b1, 1'b1},
      {8'h80, 8'h80, 12'h800, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic rdclr(input logic [2:0] a, output logic [7:0] v);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      tick();
      reg_rd = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(3'd0, v); chk("R1 evt mask", v, 8'h33);
      peek(3'd1, v); chk("R1 evt latched", v, 8'h00);
      peek(3'd2, v); chk("R1 evt live", v, 8'h00);
      peek(3'd3, v); chk("R1 upper limit", v, 8'hBA);
      peek(3'd4, v); chk("R1 lower limit", v, 8'h4B);
      peek(3'd5, v); chk("R1 ch mask", v, 8'h00);
      peek(3'd6, v); chk("R1 ch latched", v, 8'h00);
      chk("R1 irq", irq, 1'b0);

      // R3 R4 threshold table, R8 limit readback
      for (int i = 0; i < 8; i++) begin
         wr(3'd3, VEC[i][29:22]);
         wr(3'd4, VEC[i][21:14]);
         peek(3'd3, v); chk("R8 upper readback", v, VEC[i][29:22]);
         smp_data = VEC[i][13:2]; smp_valid = 1'b1;
         tick();
         smp_valid = 1'b0;
         peek(3'd2, v);
         chk("R3 upper flag", v[2], VEC[i][1]);
         chk("R4 lower flag", v[3], VEC[i][0]);
      end

      // R6 flush, then R7 line drops
      rdclr(3'd1, v);
      peek(3'd1, v); chk("R6 cleared by read", v, 8'h00);
      tick();
      chk("R7 irq low after clear", irq, 1'b0);

      // R10 sample without strobe ignored
      smp_data = 12'hFFF;
      tick();
      peek(3'd2, v); chk("R10 no strobe", v, 8'h00);

      // R2 R5 clock error pulse, masked by default
      ext_evt = 4'b0001;
      peek(3'd2, v); chk("R2 live clkerr", v, 8'h01);
      tick();
      ext_evt = 4'b0000;
      tick();
      peek(3'd1, v); chk("R5 sticky clkerr", v, 8'h01);
      chk("R7 masked source", irq, 1'b0);
      wr(3'd0, 8'h32);
      tick();
      chk("R7 unmasked source", irq, 1'b1);
      rdclr(3'd1, v); chk("R6 read value", v, 8'h01);
      tick();
      chk("R7 irq drops after read", irq, 1'b0);

      // R6 event in the read cycle is kept
      ext_evt = 4'b0100;
      reg_addr = 3'd1; reg_rd = 1'b1;
      tick();
      reg_rd = 1'b0; ext_evt = 4'b0000;
      peek(3'd1, v); chk("R6 event during read kept", v, 8'h10);
      rdclr(3'd1, v);
      peek(3'd1, v); chk("R6 second read clears", v, 8'h00);

      // R8 write to read-only address ignored
      wr(3'd1, 8'hFF);
      peek(3'd1, v); chk("R8 RO latched write", v, 8'h00);
      wr(3'd2, 8'hFF);
      peek(3'd2, v); chk("R8 RO live write", v, 8'h00);
      wr(3'd0, 8'h33);

      // R9 channel overload bank
      ovl = 2'b10;
      peek(3'd7, v); chk("R9 ch live", v, 8'h02);
      tick();
      ovl = 2'b00;
      peek(3'd6, v); chk("R9 ch latched", v, 8'h02);
      tick();
      chk("R9 ch irq unmasked", irq, 1'b1);
      wr(3'd5, 8'h02);
      peek(3'd5, v); chk("R9 ch mask readback", v, 8'h02);
      tick();
      chk("R9 ch irq masked", irq, 1'b0);
      rdclr(3'd6, v); chk("R9 ch read value", v, 8'h02);
      peek(3'd6, v); chk("R9 ch cleared", v, 8'h00);

      summary();
      $finish;
   end
endmodule